// File: doc/BRIEF.md
# DRAM ECC Error Status and Log Capture

This block records ECC error events reported by an upstream checker for up to two DRAM channels and keeps them for host software to read. Each event gives a class (correctable or uncorrectable), an 8-bit syndrome and the failing rank, bank, row and column. The block holds a global status word with one sticky flag per error class and a 64-bit log per channel that keeps the details of one error.

Within a log, an uncorrectable error displaces a correctable one. A correctable error never displaces an uncorrectable one. A second error of the class already held is dropped, so the first error stays until software clears it. Flags clear only when the host writes ones to them. Channel 1 only records events while dual-channel mode is on.

Event inputs use a valid/ready handshake, but the block never applies back-pressure. Every `evt_ready` bit is low during reset and from the first clock after reset it stays high. An event is taken in any cycle where its valid and ready bits are both high. The host port is a plain single-cycle register strobe interface, with read data returned one cycle after the read strobe.

Top module: `eccerr_capture`

## Requirements
- R1: After reset the status word and both logs read as zero and `reg_rvalid` is low.
- R2: A taken correctable event on a channel whose log is empty sets status bit 0 and loads that log. The log layout is column at bits 63:48, row at 47:32, bank at 31:29, rank at 28:27, syndrome at 23:16, uncorrectable flag at bit 1 and correctable flag at bit 0. Bits 26:24 and 15:2 read as zero.
- R3: A taken uncorrectable event sets status bit 1. If the log holds no uncorrectable error, the log is reloaded with the new details, bit 1 is set and bit 0 is cleared, even when a correctable error was held.
- R4: A correctable event that arrives while the log holds an uncorrectable error leaves the log contents unchanged, but it still sets status bit 0.
- R5: A second event of the class a log already holds does not change the log's address or syndrome fields.
- R6: Writing the status word (address 0) with bit 0 set clears status bit 0 and the correctable flag of every log. Bit 1 does the same for the uncorrectable flags. Zero bits in the write leave the flags unchanged.
- R7: Writing ones to bits 1:0 of a log's low word clears those flags of that log only. The status word and the other log are not affected. Writes to a log's high word have no effect.
- R8: When a taken event and a clearing write hit the same flag in the same cycle, the flag is set after that cycle.
- R9: While `dual_ch_en` is low, channel 1 events change neither the channel 1 log nor the status word.
- R10: A read strobe returns data one cycle later, with `reg_rvalid` high for exactly that cycle. The address map is: 0 status, 1 log0 low, 2 log0 high, 3 log1 low, 4 log1 high. Any other address reads zero.
- R11: `evt_ready` is low during reset and high in every cycle after the first clock edge out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_ch_en | input | 1 | Enables recording for channel 1 |
| evt_valid | input | 2 | Per-channel event valid |
| evt_ready | output | 2 | Per-channel event ready (never back-pressures) |
| evt_uncorr | input | 2 | Per-channel class: 1 uncorrectable, 0 correctable |
| evt_synd | input | 16 | Syndrome, 8 bits per channel |
| evt_rank | input | 4 | Rank, 2 bits per channel |
| evt_bank | input | 6 | Bank, 3 bits per channel |
| evt_row | input | 32 | Row address, 16 bits per channel |
| evt_col | input | 32 | Column address, 16 bits per channel |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |

## Verification
The bound checker checks these properties on every cycle:
- read-valid timing;
- status flags set after taken channel 0 events;
- an uncorrectable log stays frozen while no host write occurs;
- the channel 1 log stays still in single-channel mode when no write occurs;
- ready goes high after reset.

Other behaviours depend on sequences of several events, so only the bench scenarios can show them:
- the displacement order between the classes;
- first-error retention for a repeated class;
- clearing through the status word versus through a log;
- events that collide with a clearing write in the same cycle.

Random traffic on both channels with mixed writes is compared against a bench model on every read.

// File: rtl/eccerr_pkg.sv
package eccerr_pkg;
  localparam int COL_W  = 16;
  localparam int ROW_W  = 16;
  localparam int BANK_W = 3;
  localparam int RANK_W = 2;
  localparam int SYN_W  = 8;
  localparam int LOG_W  = 64;
  localparam int REG_W  = 32;

  typedef struct packed {
    logic [COL_W-1:0]  col;
    logic [ROW_W-1:0]  row;
    logic [BANK_W-1:0] bank;
    logic [RANK_W-1:0] rank;
    logic [SYN_W-1:0]  synd;
  } errloc_t;

  typedef struct packed {
    errloc_t loc;
    logic    ue;
    logic    ce;
  } errlog_t;

  // Field positions are fixed because host software decodes them.
  function automatic logic [LOG_W-1:0] pack_log(errlog_t l);
    logic [LOG_W-1:0] w;
    w = '0;
    w[63:48] = l.loc.col;
    w[47:32] = l.loc.row;
    w[31:29] = l.loc.bank;
    w[28:27] = l.loc.rank;
    w[23:16] = l.loc.synd;
    w[1]     = l.ue;
    w[0]     = l.ce;
    return w;
  endfunction
endpackage

// File: rtl/eccerr_status.sv
module eccerr_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_ce,
  input  logic       set_ue,
  input  logic       clr_ce,
  input  logic       clr_ue,
  output logic [1:0] sts_q
);
  logic [1:0] sts_d;

  // A new event outranks a clearing write in the same cycle.
  always_comb begin
    sts_d[0] = set_ce | (sts_q[0] & ~clr_ce);
    sts_d[1] = set_ue | (sts_q[1] & ~clr_ue);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end
endmodule

// File: rtl/eccerr_chan_log.sv
module eccerr_chan_log
  import eccerr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fire,
  input  logic    uncorr,
  input  errloc_t loc,
  input  logic    clr_ce,
  input  logic    clr_ue,
  output errlog_t log_q
);
  logic    take_ue, take_ce, ce_hit;
  errlog_t log_d;

  always_comb begin
    // Priority is judged against the contents held before this cycle.
    take_ue = fire & uncorr & ~log_q.ue;
    ce_hit  = fire & ~uncorr & ~log_q.ue;
    take_ce = ce_hit & ~log_q.ce;
    log_d.loc = (take_ue | take_ce) ? loc : log_q.loc;
    log_d.ue  = (fire & uncorr) | (log_q.ue & ~clr_ue);
    log_d.ce  = take_ue ? 1'b0 : (ce_hit | (log_q.ce & ~clr_ce));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) log_q <= '0;
    else        log_q <= log_d;
  end
endmodule

// File: rtl/eccerr_capture.sv
module eccerr_capture
  import eccerr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dual_ch_en,
  input  logic [NUM_CH-1:0]        evt_valid,
  output logic [NUM_CH-1:0]        evt_ready,
  input  logic [NUM_CH-1:0]        evt_uncorr,
  input  logic [NUM_CH*SYN_W-1:0]  evt_synd,
  input  logic [NUM_CH*RANK_W-1:0] evt_rank,
  input  logic [NUM_CH*BANK_W-1:0] evt_bank,
  input  logic [NUM_CH*ROW_W-1:0]  evt_row,
  input  logic [NUM_CH*COL_W-1:0]  evt_col,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [REG_W-1:0]         reg_wdata,
  output logic [REG_W-1:0]         reg_rdata,
  output logic                     reg_rvalid
);
  localparam int HALF = LOG_W / 2;

  logic                    ready_q;
  logic [NUM_CH-1:0]       ch_fire;
  errlog_t                 ch_log [NUM_CH];
  logic [NUM_CH*LOG_W-1:0] log_flat;
  logic [1:0]              sts_q;
  logic                    wr_sts, clr_ce_all, clr_ue_all;
  logic [REG_W-1:0]        rd_mux;
  logic                    unused_wdata;

  assign unused_wdata = ^reg_wdata[REG_W-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign evt_ready = {NUM_CH{ready_q}};

  assign wr_sts     = reg_wr && (reg_addr == '0);
  assign clr_ce_all = wr_sts & reg_wdata[0];
  assign clr_ue_all = wr_sts & reg_wdata[1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(1 + 2*c);
    errloc_t loc;
    logic    ch_on, wr_lo;

    assign ch_on = (c == 0) || dual_ch_en;
    assign wr_lo = reg_wr && (reg_addr == LO_A);
    assign loc.col  = evt_col [c*COL_W  +: COL_W];
    assign loc.row  = evt_row [c*ROW_W  +: ROW_W];
    assign loc.bank = evt_bank[c*BANK_W +: BANK_W];
    assign loc.rank = evt_rank[c*RANK_W +: RANK_W];
    assign loc.synd = evt_synd[c*SYN_W  +: SYN_W];
    assign ch_fire[c] = evt_valid[c] & ready_q & ch_on;

    eccerr_chan_log u_log (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (ch_fire[c]),
      .uncorr (evt_uncorr[c]),
      .loc    (loc),
      .clr_ce (clr_ce_all | (wr_lo & reg_wdata[0])),
      .clr_ue (clr_ue_all | (wr_lo & reg_wdata[1])),
      .log_q  (ch_log[c])
    );

    assign log_flat[c*LOG_W +: LOG_W] = pack_log(ch_log[c]);
  end

  eccerr_status u_sts (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ce (|(ch_fire & ~evt_uncorr)),
    .set_ue (|(ch_fire & evt_uncorr)),
    .clr_ce (clr_ce_all),
    .clr_ue (clr_ue_all),
    .sts_q  (sts_q)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_addr == '0) rd_mux = {{(REG_W-2){1'b0}}, sts_q};
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr == ADDR_W'(1 + 2*c)) rd_mux = log_flat[c*LOG_W +: HALF];
      if (reg_addr == ADDR_W'(2 + 2*c)) rd_mux = log_flat[c*LOG_W + HALF +: HALF];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/eccerr_capture_chk.sv
module eccerr_capture_chk #(
  parameter int NUM_CH = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                dual_ch_en,
  input logic [NUM_CH-1:0]   evt_valid,
  input logic [NUM_CH-1:0]   evt_ready,
  input logic [NUM_CH-1:0]   evt_uncorr,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic                reg_rvalid,
  input logic [1:0]          sts_q,
  input logic [NUM_CH*64-1:0] log_flat
);
  AST_RD_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid); // R10
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid); // R10
  AST_CE_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid[0] && evt_ready[0] && !evt_uncorr[0]) |=> sts_q[0]); // R2
  AST_UE_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid[0] && evt_ready[0] && evt_uncorr[0]) |=> sts_q[1]); // R3
  AST_UE_LOG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (log_flat[1] && !reg_wr) |=> (log_flat[1] && $stable(log_flat[63:2]))); // R4
  AST_CH1_QUIET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_ch_en && !reg_wr) |=> $stable(log_flat[127:64])); // R9
  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (&evt_ready)); // R11
endmodule

bind eccerr_capture eccerr_capture_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/eccerr_capture_test.sv
`timescale 1ns/1ps
module eccerr_capture_test;
  import eccerr_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dual_ch_en = 1'b0;
  logic [1:0]  evt_valid = '0, evt_ready, evt_uncorr = '0;
  logic [15:0] evt_synd = '0;
  logic [3:0]  evt_rank = '0;
  logic [5:0]  evt_bank = '0;
  logic [31:0] evt_row = '0, evt_col = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_rvalid;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [1:0] m_sts = '0;
  errlog_t    m_log [2];
  bit         m_ready = 0;

  always #2 clk = ~clk;

  eccerr_capture uut (.*);

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [2:0] a);
    logic [63:0] w [2];
    for (int c = 0; c < 2; c++)
      w[c] = {m_log[c].loc.col, m_log[c].loc.row, m_log[c].loc.bank, m_log[c].loc.rank,
              3'b000, m_log[c].loc.synd, 14'd0, m_log[c].ue, m_log[c].ce};
    case (a)
      3'd0: return {30'd0, m_sts};
      3'd1: return w[0][31:0];
      3'd2: return w[0][63:32];
      3'd3: return w[1][31:0];
      3'd4: return w[1][63:32];
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_edge(logic [1:0] v, logic [1:0] ue, errloc_t l0, errloc_t l1,
                            logic wr, logic [2:0] a, logic [31:0] wd, logic dual);
    errloc_t l [2];
    bit cce = wr && a == 0 && wd[0];
    bit cue = wr && a == 0 && wd[1];
    bit sce = 0, sue = 0;
    l[0] = l0; l[1] = l1;
    for (int c = 0; c < 2; c++) begin
      bit fire = v[c] && m_ready && (c == 0 || dual);
      bit lo   = wr && a == 3'(1 + 2*c);
      errlog_t p = m_log[c], n;
      n = p;
      n.ue = p.ue & !(cue || (lo && wd[1]));
      n.ce = p.ce & !(cce || (lo && wd[0]));
      if (fire && ue[c]) begin
        sue = 1;
        if (!p.ue) begin n.loc = l[c]; n.ce = 0; end
        n.ue = 1;
      end else if (fire) begin
        sce = 1;
        if (!p.ue) begin
          if (!p.ce) n.loc = l[c];
          n.ce = 1;
        end
      end
      m_log[c] = n;
    end
    m_sts[0] = sce | (m_sts[0] & !cce);
    m_sts[1] = sue | (m_sts[1] & !cue);
    m_ready = 1;
  endtask

  // Entered and left at a falling edge.
  task automatic step(logic [1:0] v, logic [1:0] ue, errloc_t l0, errloc_t l1,
                      logic wr, logic rd, logic [2:0] a, logic [31:0] wd, logic dual,
                      string req);
    logic [31:0] exp;
    evt_valid = v; evt_uncorr = ue; dual_ch_en = dual;
    {evt_col[15:0], evt_row[15:0], evt_bank[2:0], evt_rank[1:0], evt_synd[7:0]} = l0;
    {evt_col[31:16], evt_row[31:16], evt_bank[5:3], evt_rank[3:2], evt_synd[15:8]} = l1;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    exp = exp_rd(a);
    @(posedge clk);
    model_edge(v, ue, l0, l1, wr, a, wd, dual);
    @(negedge clk);
    if (rd) chk(reg_rvalid && reg_rdata == exp, req, {reg_rvalid, reg_rdata}, {1'b1, exp});
    else    chk(!reg_rvalid, "R10", reg_rvalid, 0);
    evt_valid = '0; reg_wr = 0; reg_rd = 0;
  endtask

  task automatic rd(logic [2:0] a, logic dual, string req);
    step(2'b00, 2'b00, '0, '0, 0, 1, a, 0, dual, req);
  endtask

  task automatic ev(int ch, logic u, errloc_t l, logic dual);
    step(2'(1 << ch), {u, u}, l, l, 0, 0, 0, 0, dual, "R10");
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d, logic dual);
    step(2'b00, 2'b00, '0, '0, 1, 0, a, d, dual, "R10");
  endtask

  task automatic rd_all(string req, logic dual);
    for (int a = 0; a < 5; a++) rd(3'(a), dual, req);
  endtask

  initial begin
    errloc_t la, lb;
    m_log[0] = '0; m_log[1] = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(evt_ready == 2'b00, "R11", evt_ready, 0);
    chk(reg_rvalid == 0, "R1", reg_rvalid, 0);
    rst_n = 1;
    @(posedge clk); m_ready = 1; @(negedge clk);
    chk(evt_ready == 2'b11, "R11", evt_ready, 2'b11);
    rd_all("R1", 0);

    la = errloc_t'({$urandom(), $urandom()});
    lb = errloc_t'({$urandom(), $urandom()});
    ev(0, 0, la, 0); rd_all("R2", 0);
    ev(0, 0, lb, 0); rd_all("R5", 0);
    ev(0, 1, lb, 0); rd_all("R3", 0);
    ev(0, 1, la, 0); rd_all("R5", 0);
    wr(0, 32'h1, 0); rd(0, 0, "R6");
    ev(0, 0, la, 0); rd_all("R4", 0);
    wr(0, 32'hFFFF_FFFC, 0); rd_all("R6", 0);
    wr(2, 32'hFFFF_FFFF, 0); rd_all("R7", 0);
    wr(1, 32'h2, 0); rd_all("R7", 0);
    step(2'b01, 2'b00, la, la, 1, 0, 0, 32'h1, 0, "R10"); rd_all("R8", 0);
    step(2'b01, 2'b01, lb, lb, 1, 0, 1, 32'h3, 0, "R10"); rd_all("R8", 0);
    wr(0, 32'h3, 0); rd_all("R6", 0);
    ev(1, 1, lb, 0); rd_all("R9", 0);
    ev(1, 0, la, 1); rd_all("R2", 1);
    wr(3, 32'h1, 1); rd_all("R7", 1);
    for (int a = 5; a < 8; a++) rd(3'(a), 1, "R10");

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] v  = 2'($urandom_range(0, 3) == 0 ? $urandom() : 0);
      logic [1:0] u  = 2'($urandom());
      logic       w  = ($urandom_range(0, 5) == 0);
      logic [2:0] a  = 3'($urandom_range(0, 5));
      logic       r  = ($urandom_range(0, 1) == 1);
      logic       dl = ($urandom_range(0, 3) != 0);
      la = errloc_t'({$urandom(), $urandom()});
      lb = errloc_t'({$urandom(), $urandom()});
      step(v, u, la, lb, w, r, a, 32'($urandom()), dl, "R3");
    end
    rd_all("R5", 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule